// File: doc/BRIEF.md
# Five-Port Torus Mesh Router

This block sits at one node of a square d-by-d grid of processing elements (d squared nodes in total). It moves edge messages, each a pair of vertex identifiers (the parent vertex and the discovered vertex), between a node's own processing element and its four grid neighbours. Each message carries the grid row and column of the node that owns the discovered vertex. The router delivers it one hop closer to that node, or hands it to the local element once it has arrived.

There are five input links: local, up, down, left and right. Each input link feeds its own small queue, so a whole grid uses five queues per node. The router resolves the row first and the column second. Every cycle, each output link is given to one queue head that wants it. When several heads want the same output, the fullest queue wins. Every link uses valid/ready flow control, and a transfer happens on a clock edge where both are high.

Top module: `torus_router`

## Requirements
- R1: A message is a packed word of 2*CRD_W+2*VTX_W bits. The target row is in the top CRD_W bits, followed by the target column, then the parent vertex, then the discovered vertex in the low VTX_W bits. When the target row is below `my_row`, the message leaves on the up output (port index 1).
- R2: When the target row is above `my_row`, the message leaves on the down output (index 2).
- R3: When the rows are equal, a target column below `my_col` selects left (index 3), a column above it selects right (index 4), and an equal column selects local (index 0).
- R4: Each input queue holds up to DEPTH messages and releases them in arrival order. `in_ready` of an input is low exactly while its queue is full.
- R5: When two or more queue heads want the same output, the head whose queue currently holds the most messages drives that output.
- R6: When those occupancies are equal, the lowest input index wins, in the fixed order local(0), up(1), down(2), left(3), right(4).
- R7: While an output shows valid with its ready low, it keeps valid high, and the losing or blocked heads stay queued.
- R8: A message pushed on one clock edge is presented at the output on the next cycle. After a head is taken, the next message of that queue is presented in the following cycle with no idle gap.
- R9: Heads that want different outputs are all forwarded in the same cycle, with at most one message per input per cycle.
- R10: After reset no output is valid and every `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_row | input | CRD_W | Grid row of this node |
| my_col | input | CRD_W | Grid column of this node |
| in_valid | input | 5 | Per input link: a message is offered |
| in_data | input | 5*MSG_W | Input messages, link i in slice i |
| in_ready | output | 5 | Per input link: the queue can accept |
| out_valid | output | 5 | Per output link: a message is presented |
| out_data | output | 5*MSG_W | Output messages, link o in slice o |
| out_ready | input | 5 | Per output link: downstream accepts |

## Verification
Two events can fall in the same cycle: output arbitration among contending heads, and forwarding on separate outputs. Contention is provoked by filling several queues to unequal and then equal depths, all aimed at the local output. The bench judges the stream on that output against the occupancy order it predicts, step by step, as the counts fall. Parallel forwarding is provoked by loading all five inputs in one cycle so that each targets a different output. The bench requires all five outputs valid together, then all five idle in the next cycle. An exhaustive sweep over every node position, input and target in a 4x4 grid checks the routing direction on its own.

// File: rtl/torus_rt_pkg.sv
package torus_rt_pkg;
    localparam int NPORT = 5;

    typedef enum logic [2:0] {
        P_LOCAL = 3'd0,
        P_UP    = 3'd1,
        P_DOWN  = 3'd2,
        P_LEFT  = 3'd3,
        P_RIGHT = 3'd4
    } port_e;

    function automatic logic [NPORT-1:0] port_onehot(port_e p);
        return NPORT'(1) << p;
    endfunction
endpackage

// File: rtl/tor_fifo.sv
module tor_fifo #(
    parameter int W     = 20,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    assert_count_up_R4: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> (count == $past(count) + 1'b1));
    assert_count_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (push == pop) |=> (count == $past(count)));
endmodule

// File: rtl/tor_route_calc.sv
module tor_route_calc
    import torus_rt_pkg::*;
#(
    parameter int CRD_W = 2
) (
    input  logic [CRD_W-1:0] tgt_row,
    input  logic [CRD_W-1:0] tgt_col,
    input  logic [CRD_W-1:0] here_row,
    input  logic [CRD_W-1:0] here_col,
    output port_e            dir
);
    always_comb begin
        if (tgt_row < here_row)      dir = P_UP;
        else if (tgt_row > here_row) dir = P_DOWN;
        else if (tgt_col < here_col) dir = P_LEFT;
        else if (tgt_col > here_col) dir = P_RIGHT;
        else                         dir = P_LOCAL;
    end
endmodule

// File: rtl/tor_arbiter.sv
module tor_arbiter
    import torus_rt_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic [NPORT-1:0]       req,
    input  logic [NPORT*CNT_W-1:0] occ,
    output logic [NPORT-1:0]       grant,
    output logic                   any_req
);
    logic [CNT_W-1:0] best;
    logic             found;

    assign any_req = |req;

    always_comb begin
        grant = '0;
        best  = '0;
        found = 1'b0;
        for (int i = 0; i < NPORT; i++) begin
            if (req[i] && (!found || occ[i*CNT_W +: CNT_W] > best)) begin
                grant    = '0;
                grant[i] = 1'b1;
                best     = occ[i*CNT_W +: CNT_W];
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/torus_router.sv
module torus_router
    import torus_rt_pkg::*;
#(
    parameter int DIM   = 4,
    parameter int VTX_W = 8,
    parameter int DEPTH = 4,
    localparam int CRD_W = (DIM > 1) ? $clog2(DIM) : 1,
    localparam int MSG_W = 2 * CRD_W + 2 * VTX_W,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CRD_W-1:0]       my_row,
    input  logic [CRD_W-1:0]       my_col,
    input  logic [NPORT-1:0]       in_valid,
    input  logic [NPORT*MSG_W-1:0] in_data,
    output logic [NPORT-1:0]       in_ready,
    output logic [NPORT-1:0]       out_valid,
    output logic [NPORT*MSG_W-1:0] out_data,
    input  logic [NPORT-1:0]       out_ready
);
    logic [MSG_W-1:0]       head      [NPORT];
    logic [NPORT-1:0]       want      [NPORT];
    logic [NPORT-1:0]       gnt       [NPORT];
    logic [NPORT-1:0]       q_empty, q_full, pop;
    logic [NPORT*CNT_W-1:0] occ_flat;
    logic [CRD_W-1:0]       orow      [NPORT];
    logic [CRD_W-1:0]       ocol      [NPORT];

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        port_e            dir;
        logic [CNT_W-1:0] cnt;

        tor_fifo #(.W(MSG_W), .DEPTH(DEPTH)) u_q (
            .clk   (clk),
            .rst   (rst),
            .push  (in_valid[i] & ~q_full[i]),
            .din   (in_data[i*MSG_W +: MSG_W]),
            .pop   (pop[i]),
            .dout  (head[i]),
            .empty (q_empty[i]),
            .full  (q_full[i]),
            .count (cnt)
        );

        tor_route_calc #(.CRD_W(CRD_W)) u_rt (
            .tgt_row  (head[i][MSG_W-1 -: CRD_W]),
            .tgt_col  (head[i][MSG_W-CRD_W-1 -: CRD_W]),
            .here_row (my_row),
            .here_col (my_col),
            .dir      (dir)
        );

        assign in_ready[i]                 = ~q_full[i];
        assign occ_flat[i*CNT_W +: CNT_W]  = cnt;
        assign want[i] = q_empty[i] ? '0 : port_onehot(dir);
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        logic [NPORT-1:0] col_req;
        logic [MSG_W-1:0] sel;

        always_comb begin
            for (int i = 0; i < NPORT; i++) col_req[i] = want[i][o];
        end

        tor_arbiter #(.CNT_W(CNT_W)) u_arb (
            .req     (col_req),
            .occ     (occ_flat),
            .grant   (gnt[o]),
            .any_req (out_valid[o])
        );

        always_comb begin
            sel = '0;
            for (int i = 0; i < NPORT; i++) if (gnt[o][i]) sel = sel | head[i];
        end

        assign out_data[o*MSG_W +: MSG_W] = sel;
        assign orow[o] = sel[MSG_W-1 -: CRD_W];
        assign ocol[o] = sel[MSG_W-CRD_W-1 -: CRD_W];

        assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
            (out_valid[o] && !out_ready[o]) |=> out_valid[o]);
    end

    always_comb begin
        pop = '0;
        for (int o = 0; o < NPORT; o++)
            for (int i = 0; i < NPORT; i++)
                pop[i] = pop[i] | (gnt[o][i] & out_ready[o]);
    end

    assert_up_row_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid[P_UP] |-> (orow[P_UP] < my_row));
    assert_down_row_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid[P_DOWN] |-> (orow[P_DOWN] > my_row));
    assert_local_dest_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid[P_LOCAL] |-> (orow[P_LOCAL] == my_row && ocol[P_LOCAL] == my_col));
    assert_left_col_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid[P_LEFT] |-> (orow[P_LEFT] == my_row && ocol[P_LEFT] < my_col));
    assert_right_col_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid[P_RIGHT] |-> (orow[P_RIGHT] == my_row && ocol[P_RIGHT] > my_col));
endmodule

// File: tb/sim_torus_router.sv
module sim_torus_router;
    localparam int DIM   = 4;
    localparam int VTX_W = 8;
    localparam int DEPTH = 4;
    localparam int CRD_W = 2;
    localparam int MSG_W = 2 * CRD_W + 2 * VTX_W;
    localparam int NP    = 5;

    logic                clk = 1'b0;
    logic                rst;
    logic [CRD_W-1:0]    my_row, my_col;
    logic [NP-1:0]       in_valid, in_ready, out_valid, out_ready;
    logic [NP*MSG_W-1:0] in_data, out_data;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    torus_router #(.DIM(DIM), .VTX_W(VTX_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .my_row(my_row), .my_col(my_col),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    function automatic logic [MSG_W-1:0] mk(int r, int c, int u, int v);
        return {CRD_W'(r), CRD_W'(c), VTX_W'(u), VTX_W'(v)};
    endfunction

    function automatic int exp_dir(int tr, int tc, int mr, int mc);
        if (tr < mr) return 1;
        if (tr > mr) return 2;
        if (tc < mc) return 3;
        if (tc > mc) return 4;
        return 0;
    endfunction

    function automatic logic [MSG_W-1:0] od(int o);
        return out_data[o*MSG_W +: MSG_W];
    endfunction

    task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic put(int i, logic [MSG_W-1:0] m);
        in_valid[i] = 1'b1;
        in_data[i*MSG_W +: MSG_W] = m;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                total++;
                bad++;
                $display("FAIL watchdog expired");
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [MSG_W-1:0] m;
        int d;
        rst = 1'b1; in_valid = '0; in_data = '0; out_ready = '0;
        my_row = '0; my_col = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        chk(out_valid == 5'h00, "R10 out_valid", 32'(out_valid), 0);
        chk(in_ready == 5'h1f, "R10 in_ready", 32'(in_ready), 32'h1f);

        // exhaustive routing sweep: every node, input and target (R1 R2 R3 R8)
        out_ready = '1;
        for (int mr = 0; mr < DIM; mr++)
            for (int mc = 0; mc < DIM; mc++)
                for (int i = 0; i < NP; i++)
                    for (int t = 0; t < DIM*DIM; t++) begin
                        my_row = CRD_W'(mr); my_col = CRD_W'(mc);
                        m = mk(t / DIM, t % DIM, i * 17 + t, mr * 16 + mc);
                        put(i, m);
                        @(negedge clk);
                        in_valid = '0;
                        d = exp_dir(t / DIM, t % DIM, mr, mc);
                        chk(out_valid == 5'(1 << d),
                            d == 1 ? "R1 dir" : d == 2 ? "R2 dir" : "R3 dir",
                            32'(out_valid), 32'(1 << d));
                        chk(od(d) == m, "R8 data", 32'(od(d)), 32'(m));
                        @(negedge clk);
                    end

        // contention on local output: occupancies 3 vs 1 (R5 R6 R7 R8)
        my_row = 2'd1; my_col = 2'd1; out_ready = '0;
        put(1, mk(1, 1, 0, 1)); put(3, mk(1, 1, 0, 9));
        @(negedge clk); in_valid = '0;
        put(1, mk(1, 1, 0, 2));
        @(negedge clk);
        put(1, mk(1, 1, 0, 3));
        @(negedge clk); in_valid = '0;
        chk(out_valid[0] && od(0) == mk(1, 1, 0, 1), "R5 fuller wins", 32'(od(0)), 32'(mk(1, 1, 0, 1)));
        @(negedge clk);
        chk(out_valid[0] && od(0) == mk(1, 1, 0, 1), "R7 held", 32'(od(0)), 32'(mk(1, 1, 0, 1)));
        out_ready[0] = 1'b1;
        @(negedge clk);
        chk(out_valid[0] && od(0) == mk(1, 1, 0, 2), "R5 still fuller", 32'(od(0)), 32'(mk(1, 1, 0, 2)));
        @(negedge clk);
        chk(out_valid[0] && od(0) == mk(1, 1, 0, 3), "R6 tie up beats left", 32'(od(0)), 32'(mk(1, 1, 0, 3)));
        @(negedge clk);
        chk(out_valid[0] && od(0) == mk(1, 1, 0, 9), "R8 left next", 32'(od(0)), 32'(mk(1, 1, 0, 9)));
        @(negedge clk);
        chk(out_valid == 5'h00, "R8 drained", 32'(out_valid), 0);

        // three-way tie (R6)
        out_ready = '0;
        put(0, mk(1, 1, 1, 10)); put(2, mk(1, 1, 1, 20)); put(4, mk(1, 1, 1, 40));
        @(negedge clk); in_valid = '0;
        chk(od(0) == mk(1, 1, 1, 10), "R6 local first", 32'(od(0)), 32'(mk(1, 1, 1, 10)));
        out_ready[0] = 1'b1;
        @(negedge clk);
        chk(od(0) == mk(1, 1, 1, 20), "R6 down second", 32'(od(0)), 32'(mk(1, 1, 1, 20)));
        @(negedge clk);
        chk(od(0) == mk(1, 1, 1, 40), "R6 right third", 32'(od(0)), 32'(mk(1, 1, 1, 40)));
        @(negedge clk);

        // fill one queue (R4)
        out_ready = '0;
        for (int k = 0; k < DEPTH; k++) begin
            put(4, mk(1, 1, 2, k + 50));
            @(negedge clk);
        end
        in_valid = '0;
        chk(in_ready == 5'h0f, "R4 full", 32'(in_ready), 32'h0f);
        out_ready[0] = 1'b1;
        for (int k = 0; k < DEPTH; k++) begin
            chk(out_valid[0] && od(0) == mk(1, 1, 2, k + 50), "R4 order", 32'(od(0)), 32'(mk(1, 1, 2, k + 50)));
            @(negedge clk);
        end
        chk(in_ready == 5'h1f, "R4 ready back", 32'(in_ready), 32'h1f);

        // all five outputs at once (R9)
        out_ready = '1;
        put(0, mk(0, 1, 3, 0)); put(1, mk(2, 1, 3, 1)); put(2, mk(1, 0, 3, 2));
        put(3, mk(1, 2, 3, 3)); put(4, mk(1, 1, 3, 4));
        @(negedge clk); in_valid = '0;
        chk(out_valid == 5'h1f, "R9 all valid", 32'(out_valid), 32'h1f);
        chk(od(1) == mk(0, 1, 3, 0), "R9 up", 32'(od(1)), 32'(mk(0, 1, 3, 0)));
        chk(od(2) == mk(2, 1, 3, 1), "R9 down", 32'(od(2)), 32'(mk(2, 1, 3, 1)));
        chk(od(3) == mk(1, 0, 3, 2), "R9 left", 32'(od(3)), 32'(mk(1, 0, 3, 2)));
        chk(od(4) == mk(1, 2, 3, 3), "R9 right", 32'(od(4)), 32'(mk(1, 2, 3, 3)));
        chk(od(0) == mk(1, 1, 3, 4), "R9 local", 32'(od(0)), 32'(mk(1, 1, 3, 4)));
        @(negedge clk);
        chk(out_valid == 5'h00, "R9 one cycle", 32'(out_valid), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule